// File: doc/BRIEF.md
# Phase Lock Alarm Timer

This block watches a PLL's attempt to lock onto whichever of six candidate reference inputs is currently selected. While the PLL stays unlocked on an unchanged selection, a counter advances on a once-per-second tick. If the count reaches a programmable timeout, the alarm bit of the selected input is set. Each alarmed input is also flagged as disqualified, so that a separate selection block can skip it.

The timeout is the product of a 6-bit value and a small multiplier factor. A mode input chooses how alarms go away. In manual mode, software writes a one to an input's strobe bit to clear it. In self-expiring mode, each raised alarm keeps its own age counter and drops after the same timeout has elapsed since it was raised. There is no streaming data path, so every pin is a plain control or status level.

Top module: `phlock_alarm_top`

## Requirements
- R1: Out of reset, `alarm` and `disq` are all zero.
- R2: The timeout L equals `tmo_val` times a factor taken from `mult_code`. Codes 1, 2 and 3 give the factor 1, 2 and 3, and code 0 gives 1. Bit `sel_idx` of `alarm` becomes 1 in the cycle after the L-th `tick_1hz` pulse that arrives while `pll_locked` is low and the selection is unchanged.
- R3: While `pll_locked` is high, the attempt count is held at zero. A change of `sel_idx` also returns it to zero. A full L ticks are then needed again before a raise.
- R4: When `auto_clear` is 0, a 1 on bit i of `clr_w1c` clears `alarm[i]` in the next cycle. A 1 on the bit of an input without an alarm changes nothing.
- R5: When `auto_clear` is 1, `alarm[i]` clears in the cycle after the L-th tick counted since it was raised. Each input ages on its own counter, and `clr_w1c` is ignored.
- R6: If a raise and a clear strobe for the same input fall in the same cycle, the alarm stays set.
- R7: When `tmo_val` is 0, no alarm is ever raised.
- R8: `disq[i]` equals `alarm[i]` in every cycle.
- R9: Values of `sel_idx` of 6 or above raise no alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_idx | input | 3 | Index of the selected reference input |
| pll_locked | input | 1 | PLL lock indication |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| tmo_val | input | 6 | Timeout base value in seconds; 0 disables raising |
| mult_code | input | 2 | Multiplier code (0 or 1 gives x1, 2 gives x2, 3 gives x3) |
| auto_clear | input | 1 | 1: alarms expire on their own; 0: write-one-to-clear |
| clr_w1c | input | 6 | Per-input clear strobe, used in manual mode |
| alarm | output | 6 | Per-input phase lock alarm |
| disq | output | 6 | Per-input disqualify flag |

## Verification
If the attempt counter is wrong, an alarm appears one or more ticks early or late. The bench sees this within the tick of the expected raise, because it samples on each side of that tick. If an expiry counter is shared or corrupted, two alarms that should age apart instead drop together, or too early. That shows on the first tick after the earlier expiry. A bad priority between raise and clear shows as a cleared alarm in the cycle right after the coinciding strobe.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int NUM_IN = 6;
  localparam int TMO_W  = 6;
  localparam int MUL_W  = 2;
  localparam int SEL_W  = $clog2(NUM_IN);
  localparam int LIM_W  = TMO_W + MUL_W;

  function automatic logic [LIM_W-1:0] calc_limit(input logic [TMO_W-1:0] base,
                                                  input logic [MUL_W-1:0] code);
    logic [MUL_W-1:0] fac;
    fac = (code == '0) ? MUL_W'(1) : code;
    return LIM_W'(base) * LIM_W'(fac);
  endfunction
endpackage

// File: rtl/pla_attempt_timer.sv
module pla_attempt_timer
  import pla_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int LW = LIM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel_idx,
  input  logic          pll_locked,
  input  logic          tick_1hz,
  input  logic [LW-1:0] limit,
  output logic          raise
);
  logic [SW-1:0] sel_q;
  logic [LW-1:0] cnt_q;
  logic          sel_chg;
  logic          hold;
  logic          reach;

  assign sel_chg = (sel_idx != sel_q);
  assign hold    = pll_locked || sel_chg || (limit == '0);
  assign reach   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};
  assign raise   = !hold && tick_1hz && reach;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_idx;
      if (hold || raise) cnt_q <= '0;
      else if (tick_1hz) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pla_alarm_cell.sv
module pla_alarm_cell
  import pla_pkg::*;
#(
  parameter int LW = LIM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic          auto_clear,
  input  logic          tick_1hz,
  input  logic [LW-1:0] limit,
  output logic          alarm_o
);
  logic [LW-1:0] age_q;
  logic          aged;

  assign aged = ({1'b0, age_q} + 1'b1) >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_o <= 1'b0;
      age_q   <= '0;
    end else if (set_i) begin
      alarm_o <= 1'b1;
      age_q   <= '0;
    end else if (alarm_o) begin
      if (auto_clear) begin
        if (tick_1hz) begin
          if (aged) begin
            alarm_o <= 1'b0;
            age_q   <= '0;
          end else begin
            age_q <= age_q + 1'b1;
          end
        end
      end else if (clr_i) begin
        alarm_o <= 1'b0;
        age_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/phlock_alarm_top.sv
module phlock_alarm_top
  import pla_pkg::*;
#(
  parameter int N  = NUM_IN,
  parameter int TW = TMO_W,
  parameter int MW = MUL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(N)-1:0] sel_idx,
  input  logic                 pll_locked,
  input  logic                 tick_1hz,
  input  logic [TW-1:0]        tmo_val,
  input  logic [MW-1:0]        mult_code,
  input  logic                 auto_clear,
  input  logic [N-1:0]         clr_w1c,
  output logic [N-1:0]         alarm,
  output logic [N-1:0]         disq
);
  localparam int SW = $clog2(N);
  localparam int LW = TW + MW;

  logic [LW-1:0] limit;
  logic          raise;

  assign limit = LW'(calc_limit(TMO_W'(tmo_val), MUL_W'(mult_code)));

  pla_attempt_timer #(.SW(SW), .LW(LW)) u_timer (
    .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .pll_locked(pll_locked),
    .tick_1hz(tick_1hz), .limit(limit), .raise(raise)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic hit;
    assign hit = raise && (sel_idx == SW'(i));
    pla_alarm_cell #(.LW(LW)) u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(hit), .clr_i(clr_w1c[i]),
      .auto_clear(auto_clear), .tick_1hz(tick_1hz), .limit(limit),
      .alarm_o(alarm[i])
    );
  end

  assign disq = alarm;
endmodule

// File: rtl/phlock_alarm_chk.sv
module phlock_alarm_chk #(
  parameter int N  = 6,
  parameter int TW = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [$clog2(N)-1:0] sel_idx,
  input logic                 pll_locked,
  input logic                 tick_1hz,
  input logic [TW-1:0]        tmo_val,
  input logic                 auto_clear,
  input logic [N-1:0]         clr_w1c,
  input logic [N-1:0]         alarm,
  input logic [N-1:0]         disq
);
  AST_DISQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(alarm) |-> $changed(disq)); // R8
  AST_ZERO_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmo_val) == '0) |-> ($countones(alarm & ~$past(alarm)) == 0)); // R7
  AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_locked) |-> ($countones(alarm & ~$past(alarm)) == 0)); // R3
  AST_ONE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alarm & ~$past(alarm))); // R2
  for (genvar i = 0; i < N; i++) begin : g_bit
    AST_RISE_ON_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm[i]) |-> ($past(sel_idx) == i) && $past(tick_1hz)); // R2
    AST_MANUAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(alarm[i]) && !$past(auto_clear)) |-> $past(clr_w1c[i])); // R4
    AST_AUTO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(alarm[i]) && $past(auto_clear)) |-> $past(tick_1hz)); // R5
  end
endmodule

bind phlock_alarm_top phlock_alarm_chk #(.N(N), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .pll_locked(pll_locked),
  .tick_1hz(tick_1hz), .tmo_val(tmo_val), .auto_clear(auto_clear),
  .clr_w1c(clr_w1c), .alarm(alarm), .disq(disq)
);

// File: tb/phlock_alarm_top_tb.sv
module phlock_alarm_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel_idx = '0;
  logic       pll_locked = 1'b1;
  logic       tick_1hz = 1'b0;
  logic [5:0] tmo_val = '0;
  logic [1:0] mult_code = '0;
  logic       auto_clear = 1'b0;
  logic [5:0] clr_w1c = '0;
  logic [5:0] alarm, disq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  phlock_alarm_top u_dut (
    .clk(clk), .rst_n(rst_n), .sel_idx(sel_idx), .pll_locked(pll_locked),
    .tick_1hz(tick_1hz), .tmo_val(tmo_val), .mult_code(mult_code),
    .auto_clear(auto_clear), .clr_w1c(clr_w1c), .alarm(alarm), .disq(disq)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_1hz = 1'b1;
      @(negedge clk) tick_1hz = 1'b0;
    end
  endtask

  // Clear all alarms in manual mode, hold lock, apply new settings.
  task automatic setup(input logic [5:0] t, input logic [1:0] c, input logic am,
                       input logic [2:0] s);
    @(negedge clk);
    pll_locked = 1'b1; auto_clear = 1'b0; clr_w1c = 6'h3f;
    @(negedge clk);
    clr_w1c = '0; tmo_val = t; mult_code = c; auto_clear = am; sel_idx = s;
    idle(2);
  endtask

  task automatic t_reset();
    check("R1 alarm after reset", alarm, 6'h00);
    check("R1 disq after reset", disq, 6'h00);
  endtask

  task automatic t_basic_raise();
    setup(6'd3, 2'd2, 1'b0, 3'd2);       // L = 6
    pll_locked = 1'b0;
    tick(5);
    check("R2 no alarm before L ticks", alarm, 6'h00);
    tick(1);
    check("R2 alarm on sel 2 at L", alarm, 6'h04);
    check("R8 disq mirrors alarm", disq, 6'h04);
  endtask

  task automatic t_code_zero();
    setup(6'd4, 2'd0, 1'b0, 3'd5);       // code 0 -> x1, L = 4
    pll_locked = 1'b0;
    tick(3);
    check("R2 code0 before L", alarm, 6'h00);
    tick(1);
    check("R2 code0 factor one", alarm, 6'h20);
  endtask

  task automatic t_lock_restart();
    setup(6'd2, 2'd2, 1'b0, 3'd0);       // L = 4
    pll_locked = 1'b0;
    tick(3);
    pll_locked = 1'b1;
    tick(2);
    check("R3 held while locked", alarm, 6'h00);
    pll_locked = 1'b0;
    tick(3);
    check("R3 restart after lock loss", alarm, 6'h00);
    tick(1);
    check("R3 raise after full L", alarm, 6'h01);
  endtask

  task automatic t_sel_restart();
    setup(6'd3, 2'd1, 1'b0, 3'd1);       // L = 3
    pll_locked = 1'b0;
    tick(2);
    sel_idx = 3'd3;
    idle(1);
    tick(2);
    check("R3 sel change restarts", alarm, 6'h00);
    tick(1);
    check("R3 raise on new sel", alarm, 6'h08);
  endtask

  task automatic t_manual_clear();
    setup(6'd2, 2'd1, 1'b0, 3'd1);       // L = 2
    pll_locked = 1'b0;
    tick(2);
    pll_locked = 1'b1;
    idle(1);
    check("R4 alarm set", alarm, 6'h02);
    clr_w1c = 6'h3d;                     // all but bit 1
    @(negedge clk) clr_w1c = '0;
    check("R4 clear of idle bits no effect", alarm, 6'h02);
    clr_w1c = 6'h02;
    @(negedge clk) clr_w1c = '0;
    check("R4 w1c clears", alarm, 6'h00);
  endtask

  task automatic t_raise_wins();
    setup(6'd2, 2'd1, 1'b0, 3'd4);       // L = 2
    pll_locked = 1'b0;
    tick(2);
    check("R6 first raise", alarm, 6'h10);
    tick(1);
    @(negedge clk) begin tick_1hz = 1'b1; clr_w1c = 6'h10; end
    @(negedge clk) begin tick_1hz = 1'b0; clr_w1c = '0; end
    check("R6 raise beats clear", alarm, 6'h10);
    pll_locked = 1'b1;
  endtask

  task automatic t_auto_expire();
    setup(6'd3, 2'd1, 1'b1, 3'd1);       // L = 3, self-expiring
    pll_locked = 1'b0;
    tick(3);
    check("R5 raise input 1", alarm, 6'h02);
    sel_idx = 3'd4;
    idle(1);
    clr_w1c = 6'h02;
    @(negedge clk) clr_w1c = '0;
    check("R5 w1c ignored in auto mode", alarm, 6'h02);
    tick(2);
    check("R5 input 1 still aging", alarm, 6'h02);
    tick(1);
    check("R5 input 1 expired, input 4 raised", alarm, 6'h10);
    pll_locked = 1'b1;
    tick(2);
    check("R5 input 4 ages independently", alarm, 6'h10);
    tick(1);
    check("R5 input 4 expired", alarm, 6'h00);
  endtask

  task automatic t_zero_tmo();
    setup(6'd0, 2'd3, 1'b0, 3'd2);
    pll_locked = 1'b0;
    tick(8);
    check("R7 zero timeout disables", alarm, 6'h00);
  endtask

  task automatic t_bad_sel();
    setup(6'd2, 2'd1, 1'b0, 3'd6);       // L = 2
    pll_locked = 1'b0;
    tick(5);
    check("R9 sel 6 raises nothing", alarm, 6'h00);
    sel_idx = 3'd7;
    idle(1);
    tick(5);
    check("R9 sel 7 raises nothing", alarm, 6'h00);
    check("R8 disq empty", disq, 6'h00);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_basic_raise();
    t_code_zero();
    t_lock_restart();
    t_sel_restart();
    t_manual_clear();
    t_raise_wins();
    t_auto_expire();
    t_zero_tmo();
    t_bad_sel();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule